// File: doc/BRIEF.md
# Byte-Split Serial Frame Transmitter

This block sits on the host side of a three-wire serial link and sends one 16-bit command word per transaction. A word made of a control byte in the upper half and a data byte in the lower half is accepted on a valid/ready handshake. The block then pulls an active-low frame select low and clocks the word out most significant bit first on a serial clock that idles low. Data changes on the falling clock edge so that a receiver sampling on the rising edge always sees a settled bit.

The word leaves as two 8-bit bursts. A parameterised gap of system clocks, with the serial clock held low, may separate the two bursts. Frame select stays low across the gap, so the receiver sees one 16-bit frame. After the last bit, frame select returns high and a one-cycle done pulse is raised. A minimum deselect time then passes before the next word can be taken. The serial clock half period, the gap and the deselect time are all counts of system clocks. These counts are checked against the link's nanosecond limits when the block is elaborated. An optional mode reverses the bit order inside each byte at load time, for sources that store their bytes least significant bit first.

Top module: `sftxTop`

## Requirements
- R1: The word is sent as 16 bits, bit 15 first and bit 0 last, so the upper (control) byte precedes the lower (data) byte; one bit is sampled on each rising serial clock edge.
- R2: Serial data changes only when the serial clock falls and stays constant for the whole high phase of each clock.
- R3: Every high phase and every low phase of the serial clock inside a byte lasts exactly HALF_CNT system clocks.
- R4: With GAP_CNT greater than zero, the low phase before the ninth bit lasts HALF_CNT + GAP_CNT clocks. Frame select stays low for all 16 bits, and exactly 16 rising edges occur per frame.
- R5: With GAP_CNT equal to zero, the 16 bits go out as one continuous burst, with no stretched low phase between bit 8 and bit 9.
- R6: The first rising serial clock edge comes HALF_CNT clocks after frame select falls, and the serial clock is low whenever frame select is high.
- R7: Frame select rises HALF_CNT clocks after the last falling serial clock edge. txDone is high for exactly the one cycle in which frame select has just risen, and at no other time.
- R8: inReady is low while frame select is low. After a frame, inReady returns high exactly DESEL_CNT clocks after frame select rises.
- R9: With BIT_REVERSE set, each byte is bit-reversed before sending: bit i of a byte goes out in the position of bit 7-i, and the byte order is unchanged.
- R10: After reset, frame select is high, the serial clock and txDone are low, and inReady is high.
- R11: inValid raised while inReady is low has no effect: no frame carries that word, and the number of frames equals the number of accepted handshakes.
- R12: Parameter sets whose half period, full period, setup or deselect time would violate the link's nanosecond minimums stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A command word is offered |
| inWord | input | WORD_BITS | Command word: control byte high, data byte low |
| inReady | output | 1 | Block can take a word this cycle |
| frameSelN | output | 1 | Active-low frame select |
| serClk | output | 1 | Serial clock, idles low |
| serData | output | 1 | Serial data, MSB first |
| txDone | output | 1 | One-cycle pulse when frame select rises |

## Verification
The acceptance of a new word and the end of the deselect window fall in the same cycle. When the host holds inValid high through a whole frame, the word is taken on the very first cycle inReady returns. The load then pulls frame select low right after the deselect time expires. The bench provokes this by offering each next word at once and keeping inValid high. It judges the case by requiring inReady to rise exactly DESEL_CNT clocks after frame select rose, and the following frame to keep its full setup time, bit timing and contents. Two instances run at once, one gapped without reversal and one continuous with reversal.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_GAP,
    ST_TAIL,
    ST_DESEL
  } sftxState_e;

  // Strobes from control to datapath, applied at the next clock edge
  typedef struct packed {
    logic load;        // take a new word, drop frame select, clock low
    logic shift;       // advance to the next bit
    logic clkRise;     // drive serial clock high
    logic clkFall;     // drive serial clock low
    logic selRelease;  // raise frame select and pulse done
  } sftxStrobe_t;

endpackage

// File: rtl/sftx_ctrl.sv
module sftx_ctrl
  import sftx_pkg::*;
#(
  parameter int WORD_BITS = 16,
  parameter int BYTE_BITS = 8,
  parameter int HALF_CNT  = 3,
  parameter int GAP_CNT   = 4,
  parameter int DESEL_CNT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  output sftxStrobe_t strobe
);

  localparam int CNT_MAX0 = (HALF_CNT > GAP_CNT) ? HALF_CNT : GAP_CNT;
  localparam int CNT_MAX  = (CNT_MAX0 > DESEL_CNT) ? CNT_MAX0 : DESEL_CNT;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int BIT_W    = $clog2(WORD_BITS);
  localparam logic [CNT_W-1:0] HALF_LOAD  = CNT_W'(HALF_CNT - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD   = CNT_W'((GAP_CNT > 0) ? GAP_CNT - 1 : 0);
  localparam logic [CNT_W-1:0] DESEL_LOAD = CNT_W'(DESEL_CNT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(WORD_BITS - 1);
  localparam logic [BIT_W-1:0] SPLIT_BIT  = BIT_W'(BYTE_BITS - 1);
  localparam logic             HAS_GAP    = (GAP_CNT > 0);

  sftxState_e       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [BIT_W-1:0] bitIdx, nextBitIdx;
  logic             cntZero;

  assign cntZero = (cnt == '0);
  assign inReady = (state == ST_IDLE);

  always_comb begin
    nextState  = state;
    nextCnt    = cntZero ? cnt : cnt - 1'b1;
    nextBitIdx = bitIdx;
    strobe     = '0;
    unique case (state)
      ST_IDLE: begin
        if (inValid) begin
          strobe.load = 1'b1;
          nextState   = ST_LOW;
          nextCnt     = HALF_LOAD;
          nextBitIdx  = '0;
        end
      end
      ST_LOW: begin
        if (cntZero) begin
          strobe.clkRise = 1'b1;
          nextState      = ST_HIGH;
          nextCnt        = HALF_LOAD;
        end
      end
      ST_HIGH: begin
        if (cntZero) begin
          strobe.clkFall = 1'b1;
          if (bitIdx == LAST_BIT) begin
            nextState = ST_TAIL;
            nextCnt   = HALF_LOAD;
          end else begin
            strobe.shift = 1'b1;
            nextBitIdx   = bitIdx + 1'b1;
            if (HAS_GAP && bitIdx == SPLIT_BIT) begin
              nextState = ST_GAP;
              nextCnt   = GAP_LOAD;
            end else begin
              nextState = ST_LOW;
              nextCnt   = HALF_LOAD;
            end
          end
        end
      end
      ST_GAP: begin
        if (cntZero) begin
          nextState = ST_LOW;
          nextCnt   = HALF_LOAD;
        end
      end
      ST_TAIL: begin
        if (cntZero) begin
          strobe.selRelease = 1'b1;
          nextState         = ST_DESEL;
          nextCnt           = DESEL_LOAD;
        end
      end
      ST_DESEL: begin
        if (cntZero) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextBitIdx;
    end
  end

  AST_GAP_AT_BYTE_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |-> (bitIdx == BIT_W'(BYTE_BITS))); // R4

endmodule

// File: rtl/sftx_datapath.sv
module sftx_datapath
  import sftx_pkg::*;
#(
  parameter int WORD_BITS   = 16,
  parameter int BYTE_BITS   = 8,
  parameter bit BIT_REVERSE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] inWord,
  input  sftxStrobe_t          strobe,
  output logic                 frameSelN,
  output logic                 serClk,
  output logic                 serData,
  output logic                 txDone
);

  localparam int NBYTES = WORD_BITS / BYTE_BITS;

  logic [WORD_BITS-1:0] loadWord;
  logic [WORD_BITS-1:0] shiftReg;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar i = 0; i < BYTE_BITS; i++) begin : g_bit
      if (BIT_REVERSE) begin : g_rev
        assign loadWord[b*BYTE_BITS + i] = inWord[b*BYTE_BITS + BYTE_BITS - 1 - i];
      end else begin : g_keep
        assign loadWord[b*BYTE_BITS + i] = inWord[b*BYTE_BITS + i];
      end
    end
  end

  assign serData = shiftReg[WORD_BITS-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      frameSelN <= 1'b1;
      serClk    <= 1'b0;
      txDone    <= 1'b0;
    end else begin
      txDone <= strobe.selRelease;
      if (strobe.load) begin
        shiftReg  <= loadWord;
        frameSelN <= 1'b0;
        serClk    <= 1'b0;
      end else begin
        if (strobe.shift)      shiftReg  <= {shiftReg[WORD_BITS-2:0], 1'b0};
        if (strobe.clkRise)    serClk    <= 1'b1;
        if (strobe.clkFall)    serClk    <= 1'b0;
        if (strobe.selRelease) frameSelN <= 1'b1;
      end
    end
  end

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && $past(serClk)) |-> $stable(serData)); // R2
  AST_CLK_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    frameSelN |-> !serClk); // R6
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> $rose(frameSelN)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R7

endmodule

// File: rtl/sftxTop.sv
module sftxTop
  import sftx_pkg::*;
#(
  parameter int WORD_BITS     = 16,
  parameter int BYTE_BITS     = 8,
  parameter int HALF_CNT      = 3,
  parameter int GAP_CNT       = 4,
  parameter int DESEL_CNT     = 5,
  parameter bit BIT_REVERSE   = 1'b0,
  parameter int SYS_CLK_NS    = 8,
  parameter int MIN_HALF_NS   = 13,
  parameter int MIN_PERIOD_NS = 33,
  parameter int MIN_SETUP_NS  = 5,
  parameter int MIN_DESEL_NS  = 33
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [WORD_BITS-1:0] inWord,
  output logic                 inReady,
  output logic                 frameSelN,
  output logic                 serClk,
  output logic                 serData,
  output logic                 txDone
);

  localparam int HALF_NS  = HALF_CNT * SYS_CLK_NS;
  localparam int DESEL_NS = DESEL_CNT * SYS_CLK_NS;

  // R12: timing limits enforced at elaboration
  if (HALF_CNT < 1 || DESEL_CNT < 1 || GAP_CNT < 0 ||
      HALF_NS < MIN_HALF_NS || 2 * HALF_NS < MIN_PERIOD_NS ||
      HALF_NS < MIN_SETUP_NS || DESEL_NS < MIN_DESEL_NS ||
      WORD_BITS != 2 * BYTE_BITS) begin : g_badTiming
    $error("sftxTop: parameters violate serial link timing limits");
  end

  sftxStrobe_t strobe;

  sftx_ctrl #(
    .WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS),
    .HALF_CNT(HALF_CNT), .GAP_CNT(GAP_CNT), .DESEL_CNT(DESEL_CNT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inReady(inReady), .strobe(strobe)
  );

  sftx_datapath #(
    .WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS), .BIT_REVERSE(BIT_REVERSE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .inWord(inWord), .strobe(strobe),
    .frameSelN(frameSelN), .serClk(serClk), .serData(serData), .txDone(txDone)
  );

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    !frameSelN |-> !inReady); // R8

endmodule

// File: tb/test_sftxAgent.sv
module test_sftxAgent #(
  parameter int HALF  = 3,
  parameter int GAP   = 4,
  parameter int DESEL = 5,
  parameter bit REV   = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        inValid,
  output logic [15:0] inWord,
  input  logic        inReady,
  input  logic        frameSelN,
  input  logic        serClk,
  input  logic        serData,
  input  logic        txDone,
  output int          nChecks,
  output int          nErrs,
  output logic        finished
);

  localparam int NWORDS = 6;
  logic [15:0] words [NWORDS] = '{16'hA53C, 16'h0000, 16'hFFFF, 16'h8001, 16'h1234, 16'h7EC1};

  logic [15:0] expQ[$];
  logic        drvDone;

  function automatic logic [15:0] expectOf(input logic [15:0] w);
    logic [15:0] r;
    r = w;
    if (REV) for (int i = 0; i < 8; i++) begin
      r[i]     = w[7 - i];
      r[8 + i] = w[15 - i];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%0h expected=%0h (rev=%0d gap=%0d) t=%0t", tag, act, exp, REV, GAP, $time);
    end
  endtask

  task automatic sendWord(input logic [15:0] w);
    @(posedge clk); #1;
    inValid = 1'b1;
    inWord  = w;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0;
  endtask

  // Driver
  initial begin
    inValid = 1'b0;
    inWord  = '0;
    drvDone = 1'b0;
    wait (start);
    for (int k = 0; k < NWORDS; k++) begin
      sendWord(words[k]);
      if (k == 1) begin
        // R11: word offered while busy must be ignored
        @(posedge clk); #1;
        inValid = 1'b1;
        inWord  = 16'hDEAD;
        repeat (6) @(posedge clk);
        #1 inValid = 1'b0;
      end
    end
    do @(negedge clk); while (!inReady);
    repeat (3) @(negedge clk);
    drvDone = 1'b1;
  end

  // Monitor / scoreboard
  logic        prevFs, prevClk, prevData, prevReady, dataAtRise;
  logic        resetSeen, waitReady;
  logic [15:0] bits;
  int          nBits, sinceEdge, sinceRise, accepted, frames, expLow;
  bit          fsFell, fsRose, clkRose, clkFell;

  initial begin
    nChecks = 0; nErrs = 0; finished = 1'b0;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      prevFs = 1'b1; prevClk = 1'b0; prevData = 1'b0; prevReady = 1'b1;
      resetSeen = 1'b0; waitReady = 1'b0; bits = '0; nBits = 0;
      sinceEdge = 0; sinceRise = 0; accepted = 0; frames = 0; dataAtRise = 1'b0;
    end else begin
      if (!resetSeen) begin
        resetSeen = 1'b1;
        chk(frameSelN === 1'b1, "R10 frameSelN", int'(frameSelN), 1);
        chk(serClk === 1'b0, "R10 serClk", int'(serClk), 0);
        chk(txDone === 1'b0, "R10 txDone", int'(txDone), 0);
        chk(inReady === 1'b1, "R10 inReady", int'(inReady), 1);
      end
      sinceEdge++;
      sinceRise++;
      fsFell  = prevFs && !frameSelN;
      fsRose  = !prevFs && frameSelN;
      clkRose = !prevClk && serClk;
      clkFell = prevClk && !serClk;

      if (inValid && inReady) begin
        expQ.push_back(expectOf(inWord));
        accepted++;
      end
      if (fsFell) begin
        chk(expQ.size() > 0, "R11 frame without handshake", expQ.size(), 1);
        nBits = 0;
        sinceEdge = 0;
      end
      if (clkRose) begin
        expLow = (nBits == 8) ? HALF + GAP : HALF;
        chk(sinceEdge == expLow,
            (nBits == 0) ? "R6 setup" : (nBits == 8) ? ((GAP == 0) ? "R5 no gap" : "R4 gap") : "R3 low phase",
            sinceEdge, expLow);
        chk(!frameSelN, "R4 select low", int'(frameSelN), 0);
        bits = {bits[14:0], serData};
        nBits++;
        dataAtRise = serData;
        sinceEdge = 0;
      end
      if (clkFell) begin
        chk(sinceEdge == HALF, "R3 high phase", sinceEdge, HALF);
        chk(prevData == dataAtRise, "R2 data held", int'(prevData), int'(dataAtRise));
        sinceEdge = 0;
      end
      if (fsRose) begin
        chk(sinceEdge == HALF, "R7 release delay", sinceEdge, HALF);
        chk(txDone === 1'b1, "R7 done pulse", int'(txDone), 1);
        chk(nBits == 16, "R4 bit count", nBits, 16);
        if (expQ.size() > 0) begin
          chk(bits == expQ[0], REV ? "R9 reversed word" : "R1 word", int'(bits), int'(expQ[0]));
          void'(expQ.pop_front());
        end
        frames++;
        sinceRise = 0;
        waitReady = 1'b1;
      end else if (txDone) begin
        chk(1'b0, "R7 stray done", 1, 0);
      end
      if (!prevReady && inReady) begin
        chk(waitReady && sinceRise == DESEL, "R8 deselect time", sinceRise, DESEL);
        waitReady = 1'b0;
      end
      if (frameSelN && serClk) chk(1'b0, "R6 clock while deselected", 1, 0);
      if (!frameSelN && inReady) chk(1'b0, "R8 ready while selected", 1, 0);
      if (drvDone && !finished) begin
        chk(frames == accepted && accepted == NWORDS && expQ.size() == 0,
            "R11 frames vs handshakes", frames, NWORDS);
        finished = 1'b1;
      end
      prevFs = frameSelN; prevClk = serClk; prevData = serData; prevReady = inReady;
    end
  end

endmodule

// File: tb/test_sftxTop.sv
`timescale 1ns/1ps
module test_sftxTop;

  localparam int HALF  = 3;
  localparam int DESEL = 5;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  always #4 clk = ~clk;

  logic        vA, rA, fsA, ckA, dA, dnA, finA;
  logic [15:0] wA;
  logic        vB, rB, fsB, ckB, dB, dnB, finB;
  logic [15:0] wB;
  int          cA, eA, cB, eB;
  int          cyc = 0;
  int          wd = 0;

  sftxTop #(.HALF_CNT(HALF), .GAP_CNT(4), .DESEL_CNT(DESEL), .BIT_REVERSE(1'b0)) i_sftxTop (
    .clk(clk), .rstN(rstN), .inValid(vA), .inWord(wA), .inReady(rA),
    .frameSelN(fsA), .serClk(ckA), .serData(dA), .txDone(dnA));

  sftxTop #(.HALF_CNT(HALF), .GAP_CNT(0), .DESEL_CNT(DESEL), .BIT_REVERSE(1'b1)) i_sftxTopRev (
    .clk(clk), .rstN(rstN), .inValid(vB), .inWord(wB), .inReady(rB),
    .frameSelN(fsB), .serClk(ckB), .serData(dB), .txDone(dnB));

  test_sftxAgent #(.HALF(HALF), .GAP(4), .DESEL(DESEL), .REV(1'b0)) i_agentA (
    .clk(clk), .rstN(rstN), .start(start), .inValid(vA), .inWord(wA), .inReady(rA),
    .frameSelN(fsA), .serClk(ckA), .serData(dA), .txDone(dnA),
    .nChecks(cA), .nErrs(eA), .finished(finA));

  test_sftxAgent #(.HALF(HALF), .GAP(0), .DESEL(DESEL), .REV(1'b1)) i_agentB (
    .clk(clk), .rstN(rstN), .start(start), .inValid(vB), .inWord(wB), .inReady(rB),
    .frameSelN(fsB), .serClk(ckB), .serData(dB), .txDone(dnB),
    .nChecks(cB), .nErrs(eB), .finished(finB));

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    start = 1'b1;
    while (!(finA && finB) && cyc < LIMIT) @(posedge clk);
    if (!(finA && finB)) begin
      wd = 1;
      $display("FAIL watchdog: run did not complete, actual=%0d expected<%0d cycles", cyc, LIMIT);
    end
    $display("Result: errors=%0d of %0d checks", eA + eB + wd, cA + cB + wd);
    $finish;
  end

endmodule